// File: doc/BRIEF.md
# Serial Transmitter with Break Generation

This block turns bytes written by software into a serial bit stream. A one-entry holding register accepts each write and hands it to a frame shift register as soon as that register is idle. In asynchronous mode every frame gets a low start bit and a high stop bit, and each bit is timed by counting pulses of an external baud tick. In synchronous mode the bits are sent without framing. The shift clock is either generated by the block (master) or taken from an external clock pin (slave).

Software can widen frames to nine data bits, with the ninth bit supplied from a control input. It can also ask for a break frame. The break is sent in place of the next asynchronous transmission, and the request clears itself when that frame completes. A status output reports when the shift register is empty. Transmission is gated by an enable input, and in synchronous mode an active receive-enable input blocks it.

Top module: `sertx_top`

## Requirements
- R1: After reset, `txd` is 1, `shift_empty` is 1, `hold_full` is 0, `brk_pending` is 0 and `sck_out` is 0.
- R2: An asynchronous frame is sent LSB first as one 0 start bit, the data bits and one 1 stop bit. With `cfg_fast`=0 each bit lasts TICKS_LO baud ticks, and with `cfg_fast`=1 it lasts TICKS_HI baud ticks.
- R3: With `cfg_nine`=1 a frame carries a ninth data bit after bit 7. Its value is `cfg_bit9` as sampled at the write. In asynchronous mode it sits just before the stop bit, and in synchronous mode it is the last bit. With `cfg_nine`=0 a frame carries 8 data bits.
- R4: While `cfg_tx_en` is 0 no frame starts, `shift_empty` stays 1 and a written byte stays in the holding register.
- R5: A write is accepted only while `hold_full` is 0, and a write while it is 1 is ignored. The held byte moves into the shift register when that register is empty and transmission is allowed, so back-to-back writes give consecutive frames.
- R6: A pulse on `brk_req` sets `brk_pending`. The next asynchronous load then sends a 0 start bit, BRK_ZEROS more 0 bits and a 1 stop bit, and discards the written data. `brk_pending` clears in the cycle that this frame ends.
- R7: `shift_empty` is 0 exactly from the load of a frame until its last bit has ended, and `txd` is 1 whenever `shift_empty` is 1.
- R8: In synchronous master mode (`cfg_sync`=1, `cfg_master`=1), `sck_oe` is 1 and `sck_out` idles low. Each bit has `sck_out` low for one baud tick and then high for one baud tick, and `txd` changes only together with the falling edge.
- R9: In synchronous slave mode (`cfg_sync`=1, `cfg_master`=0), `sck_oe` and `sck_out` are 0. `txd` advances one bit after each falling edge of `sck_in`, once that edge has passed through a SYNC_STAGES-flop synchroniser.
- R10: In asynchronous mode `cfg_master` has no effect and `sck_out` stays 0. In synchronous mode `cfg_fast` has no effect on bit timing.
- R11: In synchronous mode `rx_en`=1 stops any new frame from starting. In asynchronous mode `rx_en` has no effect.
- R12: A pending break has no effect on synchronous frames and stays pending through them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse from the external baud divider |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Data byte to transmit |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_sync | input | 1 | 1 = synchronous mode, 0 = asynchronous mode |
| cfg_master | input | 1 | Synchronous clock source: 1 = internal, 0 = external |
| cfg_fast | input | 1 | Asynchronous bit length: 1 = TICKS_HI, 0 = TICKS_LO |
| cfg_nine | input | 1 | 1 = nine data bits per frame |
| cfg_bit9 | input | 1 | Ninth data bit, captured at the write |
| brk_req | input | 1 | Pulse that requests a break frame |
| rx_en | input | 1 | Receive enable; blocks transmission in synchronous mode |
| sck_in | input | 1 | External shift clock for slave mode |
| txd | output | 1 | Serial data line |
| sck_out | output | 1 | Generated shift clock |
| sck_oe | output | 1 | Drive enable for the shift clock pin |
| shift_empty | output | 1 | 1 while the shift register holds no frame |
| hold_full | output | 1 | 1 while the holding register holds a byte |
| brk_pending | output | 1 | 1 while a break request waits or is being sent |

## Verification
The bench builds the block with its default parameters: 8 data bits, bit lengths of 16 and 4 ticks, 12 break zeros and a 2-flop synchroniser. It holds `baud_tick` high, so every clock is a tick. A full low-speed frame then takes 160 clocks and a break frame at high speed takes 56, which keeps every mode and the busy-length checks within a short run. With the 2-flop synchroniser, a slave clock of 12 cycles per bit leaves room to observe the three-cycle latency from each falling edge.

// File: rtl/sertx_pkg.sv
// Shared types for the serial transmitter.
// Assumes: nothing beyond the standard language.
package sertx_pkg;

    // Selects where the bit-advance strobe comes from.
    typedef enum logic [1:0] {
        TM_ASYNC    = 2'd0,
        TM_SYNC_MST = 2'd1,
        TM_SYNC_SLV = 2'd2
    } tmode_e;

    // Maps the two mode control bits onto a timing source.
    function automatic tmode_e pick_mode(input logic sync, input logic master);
        if (!sync)
            return TM_ASYNC;
        else if (master)
            return TM_SYNC_MST;
        else
            return TM_SYNC_SLV;
    endfunction

endpackage

// File: rtl/sertx_hold.sv
// One-entry holding register in front of the frame shifter.
// Captures a write only while empty and empties when the shifter takes it.
// Assumes: take is asserted only while full is 1.
module sertx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_bit9,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              bit9
);

    // Accepts a byte when empty and releases it on take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
            bit9 <= 1'b0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_stb && !full) begin
            full <= 1'b1;
            data <= wr_data;
            bit9 <= wr_bit9;
        end
    end

endmodule

// File: rtl/sertx_timing.sv
// Bit timing unit: produces a one-cycle step strobe at the end of each bit.
// Asynchronous: counts baud ticks up to the selected bit length.
// Synchronous master: each bit is one tick with the clock low, then one tick high.
// Synchronous slave: steps on each synchronised falling edge of the external clock.
// Assumes: load and busy come from the shift unit, and load happens only while idle.
module sertx_timing
    import sertx_pkg::*;
#(
    parameter int TICKS_LO    = 16,
    parameter int TICKS_HI    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  tmode_e mode,
    input  logic   fast,
    input  logic   busy,
    input  logic   load,
    input  logic   baud_tick,
    input  logic   sck_in,
    output logic   step,
    output logic   sck_out
);

    localparam int TMAX  = (TICKS_LO > TICKS_HI) ? TICKS_LO : TICKS_HI;
    localparam int CNT_W = $clog2(TMAX + 1);

    logic [CNT_W-1:0]     cnt;
    logic [CNT_W-1:0]     lim_m1;
    logic                 phase;
    logic [SYNC_STAGES:0] sck_pipe;
    logic                 sck_fall;
    logic                 async_end;
    logic                 mst_end;

    assign lim_m1    = fast ? CNT_W'(TICKS_HI - 1) : CNT_W'(TICKS_LO - 1);
    assign sck_fall  = sck_pipe[SYNC_STAGES] & ~sck_pipe[SYNC_STAGES-1];
    assign async_end = (mode == TM_ASYNC) && baud_tick && (cnt >= lim_m1);
    assign mst_end   = (mode == TM_SYNC_MST) && baud_tick && phase;

    // Raises the step strobe when the current bit has run its course.
    always_comb begin
        step = 1'b0;
        if (busy)
            step = async_end || mst_end || ((mode == TM_SYNC_SLV) && sck_fall);
    end

    // Counts baud ticks within an asynchronous bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= '0;
        else if (busy && mode == TM_ASYNC && baud_tick)
            cnt <= (cnt >= lim_m1) ? '0 : cnt + CNT_W'(1);
    end

    // Generates the master shift clock, low half first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= 1'b0;
            sck_out <= 1'b0;
        end else if (load || !busy || mode != TM_SYNC_MST) begin
            phase   <= 1'b0;
            sck_out <= 1'b0;
        end else if (baud_tick) begin
            phase   <= ~phase;
            sck_out <= ~phase;
        end
    end

    // Synchronises the external clock and keeps one older sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sck_pipe <= '0;
        else
            sck_pipe <= {sck_pipe[SYNC_STAGES-1:0], sck_in};
    end

endmodule

// File: rtl/sertx_shift.sv
// Frame shift register: builds a frame at load and shifts it out LSB first.
// Asynchronous frames are start, data, optional ninth bit, stop. A break frame is a
// start bit plus BRK_ZEROS zeros plus a stop bit. Synchronous frames carry data only.
// Assumes: load is asserted only while busy is 0.
module sertx_shift #(
    parameter int DATA_W    = 8,
    parameter int BRK_ZEROS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              sync,
    input  logic              nine,
    input  logic [DATA_W-1:0] data,
    input  logic              bit9,
    input  logic              brk_pend,
    input  logic              step,
    output logic              busy,
    output logic              txd,
    output logic              brk_done
);

    localparam int ASYNC_W = DATA_W + 3;
    localparam int BRK_W   = BRK_ZEROS + 2;
    localparam int FRAME_W = (ASYNC_W > BRK_W) ? ASYNC_W : BRK_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] sreg;
    logic [FRAME_W-1:0] vec;
    logic [CNT_W-1:0]   left;
    logic [CNT_W-1:0]   nbits;
    logic               is_brk;
    logic               last;

    assign last     = (left == CNT_W'(1));
    assign txd      = busy ? sreg[0] : 1'b1;
    assign brk_done = busy && step && last && is_brk;

    // Assembles the frame image and its bit count for the coming load.
    always_comb begin
        vec   = '1;
        nbits = '0;
        if (sync) begin
            vec[DATA_W-1:0] = data;
            if (nine)
                vec[DATA_W] = bit9;
            nbits = CNT_W'(DATA_W) + CNT_W'(nine);
        end else if (brk_pend) begin
            vec[BRK_ZEROS:0] = '0;
            nbits = CNT_W'(BRK_W);
        end else begin
            vec[0]          = 1'b0;
            vec[DATA_W:1]   = data;
            if (nine)
                vec[DATA_W+1] = bit9;
            nbits = CNT_W'(DATA_W + 2) + CNT_W'(nine);
        end
    end

    // Loads a frame, then shifts one bit per step until the count runs out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg   <= '1;
            left   <= '0;
            busy   <= 1'b0;
            is_brk <= 1'b0;
        end else if (load) begin
            sreg   <= vec;
            left   <= nbits;
            busy   <= 1'b1;
            is_brk <= !sync && brk_pend;
        end else if (busy && step) begin
            sreg <= {1'b1, sreg[FRAME_W-1:1]};
            left <= left - CNT_W'(1);
            if (last) begin
                busy   <= 1'b0;
                is_brk <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sertx_top.sv
// Serial transmitter top: holding register, frame shifter, bit timing and the
// self-clearing break request.
// Assumes: baud_tick is a one-cycle pulse and sck_in is asynchronous to clk.
module sertx_top
    import sertx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int TICKS_LO    = 16,
    parameter int TICKS_HI    = 4,
    parameter int BRK_ZEROS   = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cfg_tx_en,
    input  logic              cfg_sync,
    input  logic              cfg_master,
    input  logic              cfg_fast,
    input  logic              cfg_nine,
    input  logic              cfg_bit9,
    input  logic              brk_req,
    input  logic              rx_en,
    input  logic              sck_in,
    output logic              txd,
    output logic              sck_out,
    output logic              sck_oe,
    output logic              shift_empty,
    output logic              hold_full,
    output logic              brk_pending
);

    tmode_e            mode;
    logic              tx_go;
    logic              take;
    logic              busy;
    logic              step;
    logic              brk_done;
    logic [DATA_W-1:0] hold_data;
    logic              hold_bit9;

    assign mode        = pick_mode(cfg_sync, cfg_master);
    assign tx_go       = cfg_tx_en && !(cfg_sync && rx_en);
    assign take        = hold_full && !busy && tx_go;
    assign shift_empty = !busy;
    assign sck_oe      = cfg_sync && cfg_master;

    // Holds the break request until a break frame completes; a new request wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            brk_pending <= 1'b0;
        else
            brk_pending <= brk_req || (brk_pending && !brk_done);
    end

    sertx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .wr_bit9 (cfg_bit9),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data),
        .bit9    (hold_bit9)
    );

    sertx_shift #(.DATA_W(DATA_W), .BRK_ZEROS(BRK_ZEROS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take),
        .sync     (cfg_sync),
        .nine     (cfg_nine),
        .data     (hold_data),
        .bit9     (hold_bit9),
        .brk_pend (brk_pending),
        .step     (step),
        .busy     (busy),
        .txd      (txd),
        .brk_done (brk_done)
    );

    sertx_timing #(
        .TICKS_LO    (TICKS_LO),
        .TICKS_HI    (TICKS_HI),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_timing (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .fast      (cfg_fast),
        .busy      (busy),
        .load      (take),
        .baud_tick (baud_tick),
        .sck_in    (sck_in),
        .step      (step),
        .sck_out   (sck_out)
    );

endmodule

// File: rtl/sertx_checker.sv
// Protocol checker for the serial transmitter, attached through bind.
// Assumes: connected by name to the top-level ports.
module sertx_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_tx_en,
    input logic cfg_sync,
    input logic cfg_master,
    input logic rx_en,
    input logic txd,
    input logic sck_out,
    input logic shift_empty,
    input logic hold_full,
    input logic brk_pending
);

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |-> txd);  // R7

    AST_NO_START_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_empty && !(cfg_tx_en && !(cfg_sync && rx_en))) |=> shift_empty);  // R4

    AST_HOLD_KEPT_WHILE_SHIFTING: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_full && !shift_empty) |=> hold_full);  // R5

    AST_BRK_CLEARS_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(brk_pending) |-> $rose(shift_empty));  // R6

    AST_SCK_QUIET_UNLESS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_sync && cfg_master) |=> !sck_out);  // R10

endmodule

bind sertx_top sertx_checker u_sertx_checker (.*);

// File: tb/sertx_top_bench.sv
// Scoreboard bench: driver tasks queue expected frames, a monitor decodes the line.
module sertx_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b1;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic       cfg_tx_en = 1'b0;
    logic       cfg_sync = 1'b0;
    logic       cfg_master = 1'b0;
    logic       cfg_fast = 1'b0;
    logic       cfg_nine = 1'b0;
    logic       cfg_bit9 = 1'b0;
    logic       brk_req = 1'b0;
    logic       rx_en = 1'b0;
    logic       sck_in = 1'b0;
    logic       txd, sck_out, sck_oe, shift_empty, hold_full, brk_pending;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [15:0] bits;
        int          n;
        string       req;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    sertx_top u_sertx_top (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_stb(wr_stb),
        .wr_data(wr_data), .cfg_tx_en(cfg_tx_en), .cfg_sync(cfg_sync),
        .cfg_master(cfg_master), .cfg_fast(cfg_fast), .cfg_nine(cfg_nine),
        .cfg_bit9(cfg_bit9), .brk_req(brk_req), .rx_en(rx_en), .sck_in(sck_in),
        .txd(txd), .sck_out(sck_out), .sck_oe(sck_oe), .shift_empty(shift_empty),
        .hold_full(hold_full), .brk_pending(brk_pending)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push_exp(input logic [15:0] bits, input int n, input string req);
        exp_t e;
        e.bits = bits;
        e.n    = n;
        e.req  = req;
        exp_q.push_back(e);
    endtask

    task automatic exp_async(input logic [7:0] d, input logic nine, input logic b9,
                             input string req);
        if (nine) push_exp({5'b0, 1'b1, b9, d, 1'b0}, 11, req);
        else      push_exp({6'b0, 1'b1, d, 1'b0}, 10, req);
    endtask

    task automatic exp_break(input string req);
        push_exp(16'h2000, 14, req);
    endtask

    task automatic exp_sync(input logic [7:0] d, input logic nine, input logic b9,
                            input string req);
        if (nine) push_exp({7'b0, b9, d}, 9, req);
        else      push_exp({8'b0, d}, 8, req);
    endtask

    task automatic wr(input logic [7:0] d, input logic b9);
        @(negedge clk);
        wr_stb   = 1'b1;
        wr_data  = d;
        cfg_bit9 = b9;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic wait_hold_empty();
        while (hold_full) @(negedge clk);
    endtask

    task automatic drain();
        while (!(exp_q.size() == 0 && shift_empty && !hold_full)) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic send_timed(input logic [7:0] d, input logic b9, input int cycles,
                              input string req);
        int cnt;
        wr(d, b9);
        while (shift_empty) @(negedge clk);
        cnt = 0;
        while (!shift_empty) begin
            cnt++;
            @(negedge clk);
        end
        check(req, cnt, cycles, "busy length");
    endtask

    task automatic grab_async();
        exp_t        e;
        int          len;
        logic [15:0] got;
        if (exp_q.size() == 0) begin
            check("R5", 1, 0, "unexpected async frame");
            while (!shift_empty) @(negedge clk);
            return;
        end
        e   = exp_q.pop_front();
        len = cfg_fast ? 4 : 16;
        got = '0;
        repeat (len / 2) @(negedge clk);
        got[0] = txd;
        for (int i = 1; i < e.n; i++) begin
            repeat (len) @(negedge clk);
            got[i] = txd;
        end
        check(e.req, got, e.bits, "async frame bits");
    endtask

    task automatic grab_sync();
        exp_t        e;
        logic [15:0] got;
        logic        p;
        if (exp_q.size() == 0) begin
            check("R11", 1, 0, "unexpected sync frame");
            while (!shift_empty) @(negedge clk);
            return;
        end
        e      = exp_q.pop_front();
        got    = '0;
        got[0] = txd;
        for (int i = 1; i < e.n; i++) begin
            p = 1'b1;
            @(negedge clk);
            while (!(!p && sck_out)) begin
                p = sck_out;
                @(negedge clk);
            end
            got[i] = txd;
        end
        check(e.req, got, e.bits, "sync frame bits");
    endtask

    // Monitor: decodes frames on the line and compares against the queue.
    initial begin : monitor
        logic prev_sck;
        prev_sck = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && !cfg_sync && txd == 1'b0)
                grab_async();
            else if (rst_n && cfg_sync && cfg_master && !prev_sck && sck_out)
                grab_sync();
            prev_sck = sck_out;
        end
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Driver: stimulus and direct port checks.
    initial begin
        logic [7:0] got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", txd, 1, "txd after reset");
        check("R1", shift_empty, 1, "shift_empty after reset");
        check("R1", hold_full, 0, "hold_full after reset");
        check("R1", brk_pending, 0, "brk_pending after reset");
        check("R1", sck_out, 0, "sck_out after reset");

        // R4 / R5: disabled transmitter keeps the byte, second write ignored
        cfg_fast = 1'b1;
        wr(8'hA5, 1'b0);
        wr(8'h3C, 1'b0);
        check("R5", hold_full, 1, "hold full after write");
        repeat (60) @(negedge clk);
        check("R4", shift_empty, 1, "no load while disabled");
        check("R4", txd, 1, "line idle while disabled");
        exp_async(8'hA5, 1'b0, 1'b0, "R4");
        cfg_tx_en = 1'b1;
        drain();
        check("R5", hold_full, 0, "overflow write not kept");
        repeat (40) @(negedge clk);

        // R2 / R7: low speed frame and its length
        cfg_fast = 1'b0;
        exp_async(8'h5A, 1'b0, 1'b0, "R2");
        send_timed(8'h5A, 1'b0, 160, "R7");
        drain();

        // R3: nine-bit asynchronous frames
        cfg_fast = 1'b1;
        cfg_nine = 1'b1;
        exp_async(8'h81, 1'b1, 1'b1, "R3");
        send_timed(8'h81, 1'b1, 44, "R3");
        exp_async(8'hFF, 1'b1, 1'b0, "R3");
        wr(8'hFF, 1'b0);
        drain();
        cfg_nine = 1'b0;

        // R5: back-to-back writes
        exp_async(8'h11, 1'b0, 1'b0, "R5");
        exp_async(8'h22, 1'b0, 1'b0, "R5");
        exp_async(8'h33, 1'b0, 1'b0, "R5");
        wr(8'h11, 1'b0);
        wait_hold_empty();
        wr(8'h22, 1'b0);
        wait_hold_empty();
        wr(8'h33, 1'b0);
        drain();

        // R10 / R11: master select and receive enable ignored in async mode
        cfg_master = 1'b1;
        rx_en      = 1'b1;
        exp_async(8'h6E, 1'b0, 1'b0, "R11");
        wr(8'h6E, 1'b0);
        repeat (10) @(negedge clk);
        check("R10", sck_out, 0, "no clock in async mode");
        check("R10", sck_oe, 0, "clock pin not driven in async");
        drain();
        cfg_master = 1'b0;
        rx_en      = 1'b0;

        // R6: break frame, data discarded, request self-clears
        @(negedge clk);
        brk_req = 1'b1;
        @(negedge clk);
        brk_req = 1'b0;
        check("R6", brk_pending, 1, "break pending after request");
        exp_break("R6");
        send_timed(8'hC3, 1'b0, 56, "R6");
        drain();
        check("R6", brk_pending, 0, "break cleared after frame");
        exp_async(8'h0F, 1'b0, 1'b0, "R6");
        wr(8'h0F, 1'b0);
        drain();

        // R8 / R10 / R3: synchronous master
        cfg_sync   = 1'b1;
        cfg_master = 1'b1;
        cfg_fast   = 1'b0;
        @(negedge clk);
        check("R8", sck_oe, 1, "clock pin driven in master");
        exp_sync(8'h96, 1'b0, 1'b0, "R8");
        send_timed(8'h96, 1'b0, 16, "R8");
        cfg_fast = 1'b1;
        exp_sync(8'h96, 1'b0, 1'b0, "R10");
        send_timed(8'h96, 1'b0, 16, "R10");
        cfg_nine = 1'b1;
        exp_sync(8'hA7, 1'b1, 1'b1, "R3");
        send_timed(8'hA7, 1'b1, 18, "R3");
        cfg_nine = 1'b0;
        drain();

        // R11: receive enable blocks sync transmission
        rx_en = 1'b1;
        wr(8'h44, 1'b0);
        repeat (40) @(negedge clk);
        check("R11", shift_empty, 1, "blocked by receive enable");
        check("R11", hold_full, 1, "byte kept while blocked");
        exp_sync(8'h44, 1'b0, 1'b0, "R11");
        rx_en = 1'b0;
        drain();

        // R12: pending break ignored by sync frames, used by next async frame
        @(negedge clk);
        brk_req = 1'b1;
        @(negedge clk);
        brk_req = 1'b0;
        exp_sync(8'h5C, 1'b0, 1'b0, "R12");
        wr(8'h5C, 1'b0);
        drain();
        check("R12", brk_pending, 1, "break kept through sync frame");
        cfg_sync   = 1'b0;
        cfg_master = 1'b0;
        exp_break("R12");
        wr(8'h00, 1'b0);
        drain();
        check("R12", brk_pending, 0, "break consumed by async frame");

        // R9: synchronous slave driven by bench clock
        cfg_sync = 1'b1;
        @(negedge clk);
        check("R9", sck_oe, 0, "clock pin released in slave");
        wr(8'hB2, 1'b0);
        got = '0;
        for (int i = 0; i < 8; i++) begin
            repeat (6) @(negedge clk);
            got[i] = txd;
            check("R9", sck_out, 0, "no generated clock in slave");
            sck_in = 1'b1;
            repeat (6) @(negedge clk);
            sck_in = 1'b0;
        end
        check("R9", got, 8'hB2, "slave frame bits");
        repeat (6) @(negedge clk);
        check("R9", shift_empty, 1, "idle after eight slave edges");
        cfg_sync = 1'b0;
        repeat (10) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule